// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits on the host side of a PCI bridge. It turns the two-port scheme that software uses to reach configuration space into bus requests. One 32-bit I/O port holds a target selector: an enable flag, a bus, a device, a function and a register index. A read or write at a second I/O port window then starts one configuration transaction aimed at that selector. The bridge's own bus is fixed at 00h. A target on that bus produces a Type 0 address phase with a decoded one-hot device select. Any other bus produces a Type 1 address phase that carries the selector unchanged.

The block also produces broadcast special cycles. One way is to write the data port while the selector names device 31, function 7, register 0 on the local bus; the written value then becomes the message. The other way is a direct request for a HALT or SHUTDOWN message. A simple request/acknowledge pair stands in for the bus engine: the block raises `bus_req` with the command, address, byte enables and write data, and holds them until `bus_ack`. Read data returns to the host on a one-cycle `hst_ack`.

Top module: `cfgx_top`

## Requirements
- R1: After reset the selector register is zero, `bus_req`, `hst_ack` and `brd_ack` are low, and the first read of the selector port returns 0.
- R2: A write at I/O address CF8h with all four byte enables set loads the selector. A later read of CF8h returns the value with bits 30:24 and 1:0 forced to zero. The selector fields are enable = bit 31, bus = 23:16, device = 15:11, function = 10:8 and register = 7:2.
- R3: A write at CF8h with any byte enable clear leaves the selector unchanged.
- R4: A data-port access (CFCh–CFFh) while the enable bit is clear starts no bus cycle. A read returns FFFF_FFFFh, a write returns 0 and is discarded.
- R5: With enable set and bus = 00h, the address phase is Type 0. Bit 11+device is set for device 0..20 (no select bit for 21..31), function is in 10:8, register in 7:2, and bits 1:0 are 00.
- R6: With enable set and bus ≠ 00h, the address phase is Type 1: {8'h00, bus, device, function, register, 2'b01}.
- R7: Configuration reads use command 1010b and writes use 1011b. The host byte enables and write data pass through unchanged. A read returns the `bus_rdata` sampled with `bus_ack`, and a write returns 0.
- R8: A data-port write with the special pattern (enable, bus 00h, device 31, function 7, register 0) issues command 0001b with address 0. The written value and the byte enables pass through.
- R9: A data-port read with the special pattern starts no bus cycle and returns FFFF_FFFFh.
- R10: A direct broadcast request issues command 0001b with address 0, byte enables 1111b, and data 0000_0001h for HALT (`brd_halt`=1) or 0000_0000h for SHUTDOWN. It completes with one cycle of `brd_ack`. A pending host request is served first, and `hst_ack` and `brd_ack` are never high together.
- R11: One transaction at a time. `bus_req` and its fields hold until `bus_ack` is sampled. The completion ack is high for exactly the cycle after `bus_ack` is sampled, or the cycle after acceptance for accesses that start no bus cycle.
- R12: Host accesses at any other I/O address start no bus cycle and change nothing. A read returns FFFF_FFFFh, a write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host I/O request, held until `hst_ack` |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_waddr | input | IO_AW-2 | I/O dword address (byte address bits IO_AW-1:2) |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Host completion, one cycle |
| hst_rdata | output | 32 | Host read data, valid with `hst_ack` |
| brd_req | input | 1 | Direct broadcast request, held until `brd_ack` |
| brd_halt | input | 1 | 1 = HALT message, 0 = SHUTDOWN |
| brd_ack | output | 1 | Broadcast completion, one cycle |
| bus_req | output | 1 | Request to the bus engine |
| bus_cmd | output | 4 | Bus command |
| bus_addr | output | 32 | Address-phase value |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Write or message data |
| bus_ack | input | 1 | Bus engine completion |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The assertions assume a well-behaved host. It keeps `hst_req` and its address, direction, enables and data steady from the request until it sees `hst_ack`, and drops the request in that ack cycle. The same rule holds for `brd_req` and `brd_halt`. They also assume the bus engine raises `bus_ack` only while `bus_req` is high, for a single cycle. The bench drives requests only on falling edges and releases them on the falling edge where it observes the ack. Its engine model answers after a programmable wait of zero to two cycles and pulses `bus_ack` once per request. That keeps every stimulus inside those assumptions, including the case where host and broadcast requests arrive in the same cycle.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int unsigned DW = 32;

   localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
   localparam logic [3:0] CMD_SPECIAL = 4'b0001;

   localparam logic [15:0] MSG_SHUTDOWN = 16'h0000;
   localparam logic [15:0] MSG_HALT     = 16'h0001;

   // bits the selector register keeps: enable, bus, device, function, register
   localparam logic [DW-1:0] SEL_KEEP_MASK = 32'h80FF_FFFC;

   // number of device select lines a Type 0 phase can carry (bits 31:11)
   localparam int unsigned IDSEL_MAX = 21;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUS,
      ST_DONE
   } seq_st_e;

   typedef struct packed {
      logic [3:0]    cmd;
      logic [DW-1:0] addr;
      logic [3:0]    be;
      logic [DW-1:0] data;
   } bus_op_t;
endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
   import cfgx_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (load) q <= wdata & SEL_KEEP_MASK;
   end

   // R2
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q[30:24] == 7'h00) && (q[1:0] == 2'b00)
               && (q[31] == $past(wdata[31])) && (q[23:2] == $past(wdata[23:2])));

   // R3
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
   import cfgx_pkg::*;
#(
   parameter int unsigned          IO_AW       = 16,
   parameter logic [IO_AW-1:0]     SEL_PORT    = 16'h0CF8,
   parameter logic [IO_AW-1:0]     DATA_PORT   = 16'h0CFC,
   parameter logic [7:0]           LOCAL_BUS   = 8'h00,
   parameter int unsigned          IDSEL_LINES = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    sel_q,
   input  logic             hst_wr,
   input  logic [IO_AW-3:0] hst_waddr,
   input  logic [3:0]       hst_be,
   input  logic [DW-1:0]    hst_wdata,
   output logic             needs_bus,
   output logic             sel_we,
   output bus_op_t          op,
   output logic [DW-1:0]    local_rdata
);
   localparam logic [IO_AW-3:0] SEL_DW  = SEL_PORT[IO_AW-1:2];
   localparam logic [IO_AW-3:0] DATA_DW = DATA_PORT[IO_AW-1:2];

   logic       en;
   logic [7:0] bus_no;
   logic [4:0] dev_no;
   logic [2:0] fn_no;
   logic [5:0] reg_no;

   assign en     = sel_q[31];
   assign bus_no = sel_q[23:16];
   assign dev_no = sel_q[15:11];
   assign fn_no  = sel_q[10:8];
   assign reg_no = sel_q[7:2];

   logic at_sel, at_data, on_local, special_hit;
   assign at_sel      = (hst_waddr == SEL_DW);
   assign at_data     = (hst_waddr == DATA_DW);
   assign on_local    = (bus_no == LOCAL_BUS);
   assign special_hit = en && on_local && (dev_no == 5'h1F) && (fn_no == 3'h7)
                        && (reg_no == 6'h00);

   // one-hot device select for Type 0 phases
   logic [IDSEL_MAX-1:0] idsel;
   for (genvar i = 0; i < IDSEL_MAX; i++) begin : g_idsel
      if (i < IDSEL_LINES) begin : g_line
         assign idsel[i] = (dev_no == 5'(i));
      end else begin : g_none
         assign idsel[i] = 1'b0;
      end
   end

   logic [DW-1:0] t0_addr, t1_addr;
   assign t0_addr = {idsel, fn_no, reg_no, 2'b00};
   assign t1_addr = {8'h00, bus_no, dev_no, fn_no, reg_no, 2'b01};

   always_comb begin
      needs_bus   = 1'b0;
      sel_we      = 1'b0;
      op          = '0;
      local_rdata = '1;
      if (at_sel) begin
         local_rdata = sel_q;
         sel_we      = hst_wr && (hst_be == 4'hF);
      end else if (at_data && en) begin
         if (special_hit) begin
            if (hst_wr) begin
               needs_bus = 1'b1;
               op.cmd    = CMD_SPECIAL;
               op.addr   = '0;
               op.be     = hst_be;
               op.data   = hst_wdata;
            end
         end else begin
            needs_bus = 1'b1;
            op.cmd    = hst_wr ? CMD_CFG_WR : CMD_CFG_RD;
            op.addr   = on_local ? t0_addr : t1_addr;
            op.be     = hst_be;
            op.data   = hst_wr ? hst_wdata : '0;
         end
      end
      if (hst_wr) local_rdata = '0;
   end

   // R5
   t0_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (needs_bus && op.cmd != CMD_SPECIAL && op.addr[1:0] == 2'b00)
         |-> ($countones(op.addr[31:11]) <= 1));

   // R9
   special_read_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_data && special_hit && !hst_wr) |-> !needs_bus);

   // R4
   disabled_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_data && !en) |-> !needs_bus);
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
   import cfgx_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_req,
   input  logic          hst_wr,
   input  logic          needs_bus,
   input  bus_op_t       op_in,
   input  logic [DW-1:0] local_rdata,
   input  logic          brd_req,
   input  logic          brd_halt,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata,
   output logic          take,
   output logic          hst_ack,
   output logic          brd_ack,
   output logic [DW-1:0] hst_rdata,
   output bus_op_t       op_out,
   output logic          bus_req
);
   seq_st_e state;
   logic    from_brd;
   logic    is_rd;

   assign take    = (state == ST_IDLE) && hst_req;
   assign bus_req = (state == ST_BUS);
   assign hst_ack = (state == ST_DONE) && !from_brd;
   assign brd_ack = (state == ST_DONE) && from_brd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         from_brd  <= 1'b0;
         is_rd     <= 1'b0;
         hst_rdata <= '0;
         op_out    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (hst_req) begin
                  from_brd <= 1'b0;
                  is_rd    <= !hst_wr;
                  if (needs_bus) begin
                     op_out <= op_in;
                     state  <= ST_BUS;
                  end else begin
                     hst_rdata <= local_rdata;
                     state     <= ST_DONE;
                  end
               end else if (brd_req) begin
                  from_brd    <= 1'b1;
                  is_rd       <= 1'b0;
                  op_out.cmd  <= CMD_SPECIAL;
                  op_out.addr <= '0;
                  op_out.be   <= 4'hF;
                  op_out.data <= {16'h0000, brd_halt ? MSG_HALT : MSG_SHUTDOWN};
                  state       <= ST_BUS;
               end
            end
            ST_BUS: begin
               if (bus_ack) begin
                  hst_rdata <= is_rd ? bus_rdata : '0;
                  state     <= ST_DONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req);

   // R11
   bus_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> ($stable(op_out.addr) && $stable(op_out.cmd)
                                 && $stable(op_out.be) && $stable(op_out.data)));

   // R11
   ack_follows_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> (hst_ack || brd_ack));

   // R11
   hst_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hst_ack |=> !hst_ack);

   // R10
   ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hst_ack && brd_ack));
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
   import cfgx_pkg::*;
#(
   parameter int unsigned      IO_AW       = 16,
   parameter logic [IO_AW-1:0] SEL_PORT    = 16'h0CF8,
   parameter logic [IO_AW-1:0] DATA_PORT   = 16'h0CFC,
   parameter logic [7:0]       LOCAL_BUS   = 8'h00,
   parameter int unsigned      IDSEL_LINES = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hst_req,
   input  logic             hst_wr,
   input  logic [IO_AW-3:0] hst_waddr,
   input  logic [3:0]       hst_be,
   input  logic [31:0]      hst_wdata,
   output logic             hst_ack,
   output logic [31:0]      hst_rdata,
   input  logic             brd_req,
   input  logic             brd_halt,
   output logic             brd_ack,
   output logic             bus_req,
   output logic [3:0]       bus_cmd,
   output logic [31:0]      bus_addr,
   output logic [3:0]       bus_be,
   output logic [31:0]      bus_wdata,
   input  logic             bus_ack,
   input  logic [31:0]      bus_rdata
);
   if (IO_AW < 12 || IO_AW > 32) begin : g_bad_aw
      $error("cfgx_top: IO_AW must lie in 12..32");
   end
   if (SEL_PORT[1:0] != 2'b00 || DATA_PORT[1:0] != 2'b00) begin : g_bad_align
      $error("cfgx_top: ports must be dword aligned");
   end
   if (SEL_PORT == DATA_PORT) begin : g_bad_overlap
      $error("cfgx_top: selector and data ports must differ");
   end
   if (IDSEL_LINES < 1 || IDSEL_LINES > IDSEL_MAX) begin : g_bad_idsel
      $error("cfgx_top: IDSEL_LINES must lie in 1..21");
   end

   logic [DW-1:0] sel_q;
   logic          needs_bus, sel_we, take;
   bus_op_t       dec_op, cur_op;
   logic [DW-1:0] local_rdata;

   cfgx_sel_reg u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take && sel_we),
      .wdata (hst_wdata),
      .q     (sel_q)
   );

   cfgx_decode #(
      .IO_AW       (IO_AW),
      .SEL_PORT    (SEL_PORT),
      .DATA_PORT   (DATA_PORT),
      .LOCAL_BUS   (LOCAL_BUS),
      .IDSEL_LINES (IDSEL_LINES)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_q       (sel_q),
      .hst_wr      (hst_wr),
      .hst_waddr   (hst_waddr),
      .hst_be      (hst_be),
      .hst_wdata   (hst_wdata),
      .needs_bus   (needs_bus),
      .sel_we      (sel_we),
      .op          (dec_op),
      .local_rdata (local_rdata)
   );

   cfgx_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .hst_req     (hst_req),
      .hst_wr      (hst_wr),
      .needs_bus   (needs_bus),
      .op_in       (dec_op),
      .local_rdata (local_rdata),
      .brd_req     (brd_req),
      .brd_halt    (brd_halt),
      .bus_ack     (bus_ack),
      .bus_rdata   (bus_rdata),
      .take        (take),
      .hst_ack     (hst_ack),
      .brd_ack     (brd_ack),
      .hst_rdata   (hst_rdata),
      .op_out      (cur_op),
      .bus_req     (bus_req)
   );

   assign bus_cmd   = cur_op.cmd;
   assign bus_addr  = cur_op.addr;
   assign bus_be    = cur_op.be;
   assign bus_wdata = cur_op.data;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!bus_req && !hst_ack && !brd_ack && sel_q == '0));
endmodule

// File: tb/cfgx_top_tb.sv
module cfgx_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0, hst_wr = 1'b0;
   logic [13:0] hst_waddr = '0;
   logic [3:0]  hst_be = '0;
   logic [31:0] hst_wdata = '0;
   logic        hst_ack;
   logic [31:0] hst_rdata;
   logic        brd_req = 1'b0, brd_halt = 1'b0, brd_ack;
   logic        bus_req;
   logic [3:0]  bus_cmd, bus_be;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   always #10 clk = ~clk;   // 50 MHz

   cfgx_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .hst_req(hst_req), .hst_wr(hst_wr), .hst_waddr(hst_waddr), .hst_be(hst_be),
      .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
      .brd_req(brd_req), .brd_halt(brd_halt), .brd_ack(brd_ack),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int bus_lat = 0;
   int wcnt = 0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // ---------------- reference model ----------------
   int          m_state = 0;   // 0 idle, 1 on bus, 2 completing
   bit          m_src = 0;     // completion belongs to broadcast
   bit          m_rd = 0;
   logic [31:0] m_sel = '0;
   logic [3:0]  m_cmd = '0, m_be = '0;
   logic [31:0] m_addr = '0, m_data = '0, m_rdata = '0;
   string       m_tag = "R1";

   task automatic model_accept();
      int          port;
      logic        en;
      logic [7:0]  bno;
      int          dno, fno, rno;
      port = int'(hst_waddr) * 4;
      en   = m_sel[31];
      bno  = m_sel[23:16];
      dno  = int'(m_sel[15:11]);
      fno  = int'(m_sel[10:8]);
      rno  = int'(m_sel[7:2]);
      m_src = 0;
      m_rd  = !hst_wr;
      m_state = 2;
      if (port == 'hCF8) begin
         if (hst_wr) begin
            m_rdata = 0;
            if (hst_be == 4'hF) begin
               m_sel = hst_wdata & 32'h80FF_FFFC;
               m_tag = "R2";
            end else m_tag = "R3";
         end else begin
            m_rdata = m_sel;
            m_tag = "R2";
         end
      end else if (port == 'hCFC) begin
         if (!en) begin
            m_rdata = hst_wr ? 32'h0 : 32'hFFFF_FFFF;
            m_tag = "R4";
         end else if (bno == 0 && dno == 31 && fno == 7 && rno == 0) begin
            if (hst_wr) begin
               m_cmd = 4'b0001; m_addr = 0; m_be = hst_be; m_data = hst_wdata;
               m_tag = "R8"; m_state = 1;
            end else begin
               m_rdata = 32'hFFFF_FFFF;
               m_tag = "R9";
            end
         end else begin
            m_cmd = hst_wr ? 4'b1011 : 4'b1010;
            m_be  = hst_be;
            m_data = hst_wr ? hst_wdata : 32'h0;
            if (bno == 0) begin
               m_addr = (fno << 8) | (rno << 2);
               if (dno < 21) m_addr = m_addr | (32'h1 << (11 + dno));
               m_tag = "R5";
            end else begin
               m_addr = {8'h00, bno, m_sel[15:2], 2'b01};
               m_tag = "R6";
            end
            m_state = 1;
         end
      end else begin
         m_rdata = hst_wr ? 32'h0 : 32'hFFFF_FFFF;
         m_tag = "R12";
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_sel = 0; m_src = 0;
      end else begin
         cyc++;
         case (m_state)
            0: begin
               if (hst_req) model_accept();
               else if (brd_req) begin
                  m_src = 1; m_rd = 0; m_cmd = 4'b0001; m_addr = 0; m_be = 4'hF;
                  m_data = brd_halt ? 32'h1 : 32'h0;
                  m_tag = "R10"; m_state = 1;
               end
            end
            1: if (bus_ack) begin
               m_rdata = m_rd ? bus_rdata : 32'h0;
               m_state = 2;
            end
            default: m_state = 0;
         endcase
         #5;
         chk("R11", "bus_req", 32'(bus_req), 32'(m_state == 1));
         chk("R11", "hst_ack", 32'(hst_ack), 32'(m_state == 2 && !m_src));
         chk("R10", "brd_ack", 32'(brd_ack), 32'(m_state == 2 && m_src));
         if (m_state == 1) begin
            chk(m_tag, "bus_addr", bus_addr, m_addr);
            chk((m_tag == "R5" || m_tag == "R6") ? "R7" : m_tag, "bus_cmd", 32'(bus_cmd), 32'(m_cmd));
            chk((m_tag == "R5" || m_tag == "R6") ? "R7" : m_tag, "bus_be", 32'(bus_be), 32'(m_be));
            chk((m_tag == "R5" || m_tag == "R6") ? "R7" : m_tag, "bus_wdata", bus_wdata, m_data);
         end
         if (m_state == 2 && !m_src)
            chk((m_tag == "R5" || m_tag == "R6") ? "R7" : m_tag, "hst_rdata", hst_rdata, m_rdata);
         if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R11 watchdog: actual %0d cycles expected below 100000", cyc);
            finish_run();
         end
      end
   end

   // ---------------- bus engine stand-in ----------------
   always @(negedge clk) begin
      if (bus_req && !bus_ack && wcnt >= bus_lat) begin
         bus_ack   = 1'b1;
         bus_rdata = bus_addr ^ 32'hA5A5_0F0F;
         wcnt      = 0;
      end else begin
         if (bus_req && !bus_ack) wcnt++;
         bus_ack = 1'b0;
      end
   end

   // ---------------- stimulus ----------------
   task automatic host_io(input bit wr, input int port, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      hst_req = 1'b1; hst_wr = wr; hst_waddr = 14'(port >> 2); hst_be = be; hst_wdata = wd;
      do @(negedge clk); while (!hst_ack);
      rd = hst_rdata;
      hst_req = 1'b0;
   endtask

   task automatic bcast(input bit halt);
      @(negedge clk);
      brd_req = 1'b1; brd_halt = halt;
      do @(negedge clk); while (!brd_ack);
      brd_req = 1'b0;
   endtask

   function automatic logic [31:0] sel(bit en, int b, int d, int f, int r);
      return {en, 7'h00, 8'(b), 5'(d), 3'(f), 6'(r), 2'b00};
   endfunction

   initial begin
      logic [31:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "bus_req after reset", 32'(bus_req), 0);
      chk("R1", "acks after reset", 32'(hst_ack | brd_ack), 0);
      host_io(0, 'hCF8, 4'hF, 0, rd);
      chk("R1", "selector after reset", rd, 0);

      // R4: disabled data port
      host_io(0, 'hCFC, 4'hF, 0, rd);
      host_io(1, 'hCFC, 4'hF, 32'h1111_2222, rd);
      // R2: reserved bits dropped
      host_io(1, 'hCF8, 4'hF, 32'h7F12_3457, rd);
      host_io(0, 'hCF8, 4'hF, 0, rd);
      chk("R2", "selector readback", rd, 32'h0012_3454);
      // R3: partial write ignored
      host_io(1, 'hCF8, 4'h3, 32'hFFFF_FFFF, rd);
      host_io(0, 'hCF8, 4'hF, 0, rd);
      chk("R3", "selector after partial write", rd, 32'h0012_3454);

      // R5 / R7: Type 0 on local bus
      host_io(1, 'hCF8, 4'hF, sel(1, 0, 3, 2, 16), rd);
      bus_lat = 0;
      host_io(0, 'hCFC, 4'hF, 0, rd);
      host_io(1, 'hCFE, 4'h4, 32'h00AB_0000, rd);
      host_io(1, 'hCF8, 4'hF, sel(1, 0, 20, 7, 63), rd);
      bus_lat = 1;
      host_io(0, 'hCFC, 4'h3, 0, rd);
      host_io(1, 'hCF8, 4'hF, sel(1, 0, 25, 1, 4), rd);
      host_io(1, 'hCFC, 4'hF, 32'hDEAD_BEEF, rd);

      // R6: Type 1
      bus_lat = 2;
      host_io(1, 'hCF8, 4'hF, sel(1, 5, 9, 4, 33), rd);
      host_io(0, 'hCFC, 4'hF, 0, rd);
      host_io(1, 'hCF8, 4'hF, sel(1, 3, 31, 7, 0), rd);
      host_io(1, 'hCFC, 4'hF, 32'h0000_5555, rd);

      // R8 / R9: special pattern on local bus
      host_io(1, 'hCF8, 4'hF, sel(1, 0, 31, 7, 0), rd);
      bus_lat = 1;
      host_io(1, 'hCFC, 4'hF, 32'h1234_0002, rd);
      host_io(0, 'hCFC, 4'hF, 0, rd);
      chk("R9", "special read", rd, 32'hFFFF_FFFF);

      // R12: unrelated I/O address
      host_io(0, 'h0080, 4'hF, 0, rd);
      chk("R12", "other port read", rd, 32'hFFFF_FFFF);
      host_io(1, 'h0CF4, 4'hF, 32'h0, rd);
      host_io(0, 'hCF8, 4'hF, 0, rd);
      chk("R12", "selector untouched", rd, sel(1, 0, 31, 7, 0));

      // R10: direct broadcasts and priority
      bcast(1);
      bcast(0);
      host_io(1, 'hCF8, 4'hF, sel(1, 0, 1, 0, 2), rd);
      fork
         host_io(0, 'hCFC, 4'hF, 0, rd);
         bcast(1);
      join

      // mixed traffic
      for (int i = 0; i < 24; i++) begin
         bus_lat = i % 3;
         host_io(1, 'hCF8, 4'hF, sel(i % 5 != 0, (i % 4 == 0) ? 7 : 0, (i * 7) % 32, i % 8, (i * 3) % 64), rd);
         host_io(i % 2, 'hCFC + (i % 4), 4'(1 << (i % 4)), 32'h0101_0101 * i, rd);
      end
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule